// File: doc/BRIEF.md
# Filtered Performance Counter with Overflow Flag

This block is one programmable 64-bit hardware event counter, paired with a 64-bit event-control register. An increment request arrives from an event source that lies outside the block. The block then checks the hart's current privilege level and virtualization state against five per-mode inhibit bits. It also checks a global count-inhibit input and the counter's own index. If none of them blocks the request, the count rises by one. When the count passes all ones, it returns to zero and sets a sticky overflow flag in the control register. If that flag was clear beforehand, the block also raises a local overflow interrupt request. The request holds until software writes the control register with the flag cleared.

Software accesses both registers through write strobes and a shared 64-bit data bus. Both registers are always visible on outputs. The width input picks the access path. In 64-bit width, one write loads a whole register. In 32-bit width, a write loads either the low or the high half from the low 32 data bits, and a half-select input picks which half. The storage is laid out so that the flag and inhibit bits sit at bits 31..26 of the upper half, which are bits 63..58 of the whole register.

Top module: `hpc_filtered_counter`

## Requirements
- R1: After reset, the count, the control register and the interrupt request are all zero.
- R2: When counting is enabled, each cycle with `incr_i` high adds exactly one to the count, and the new value shows on `cnt_o` after the next clock edge.
- R3: The control-register inhibit bits are placed as follows: bit 62 blocks machine mode (`priv_i`=2'b11), bit 61 blocks supervisor (2'b01), bit 60 blocks user (2'b00), bit 59 blocks virtualized supervisor and bit 58 blocks virtualized user. Bits 61 and 60 apply only while `virt_i` is 0. Bits 59 and 58 apply only while `virt_i` is 1. Machine mode ignores `virt_i`.
- R4: No increment happens while `inhibit_i` is high, or while `idx_i` is outside the programmable range 3 to 31 inclusive.
- R5: An increment taken while the count is all ones returns the count to zero.
- R6: On that wrap, if the overflow flag (bit 63) was clear, the flag is set and `irq_o` rises at the same edge.
- R7: On a wrap while the overflow flag is already set, no new interrupt request is raised. The flag also stays set until a control write clears it.
- R8: `irq_o` stays high until a control-register write leaves bit 63 at 0. It is low after that edge. A write that leaves bit 63 at 1 keeps `irq_o` as it was.
- R9: In 32-bit width, the low half counts on its own until it is all ones. The next increment carries into the high half. Both halves clear together only when both are all ones.
- R10: In 64-bit width, a write loads all 64 bits. In 32-bit width, a write with `whi_i`=0 loads bits 31..0, and a write with `whi_i`=1 loads bits 63..32, in both cases from `wdata_i[31:0]`. The other half keeps its value.
- R11: A counter write in the same cycle as an increment wins, and the increment is dropped. A control write in the same cycle as a wrap wins over the flag update, and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode32_i | input | 1 | 1 selects 32-bit access width |
| priv_i | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| virt_i | input | 1 | Virtualization active |
| inhibit_i | input | 1 | Global count-inhibit bit for this counter |
| idx_i | input | 6 | Index of this counter |
| incr_i | input | 1 | Event increment request |
| cnt_we_i | input | 1 | Counter write strobe |
| evt_we_i | input | 1 | Control-register write strobe |
| whi_i | input | 1 | Half select for 32-bit writes |
| wdata_i | input | 64 | Write data |
| cnt_o | output | 64 | Current count |
| evt_o | output | 64 | Current control register |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
All three outputs come straight from registers. The effect of any stimulus therefore shows exactly one clock edge after the cycle in which it is driven, and this holds for increments, wraps, flag setting, interrupt changes and writes alike. The driver applies each stimulus half a period before a rising edge. It then queues the values the requirements predict for that edge. The monitor pops and compares one queued item at the following falling edge, so every comparison lands on the one cycle in which the result is due. It never lands on the cycle of the stimulus itself.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam int CNT_W  = 64;
  localparam int HALF_W = 32;
  localparam int CTL_W  = 6;
  // control bit positions within the 64-bit control register
  localparam int OF_POS    = 63;
  localparam int MINH_POS  = 62;
  localparam int SINH_POS  = 61;
  localparam int UINH_POS  = 60;
  localparam int VSINH_POS = 59;
  localparam int VUINH_POS = 58;
  localparam int CTL_LSB   = VUINH_POS;

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  typedef struct packed {
    logic of;
    logic minh;
    logic sinh;
    logic uinh;
    logic vsinh;
    logic vuinh;
  } ctl_t;
endpackage

// File: rtl/hpc_mode_filter.sv
module hpc_mode_filter
  import hpc_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int IDX_LO = 3,
  parameter int IDX_HI = 31
) (
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  input  logic             inhibit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  ctl_t             ctl_i,
  input  logic             incr_i,
  output logic             take_o
);
  priv_e priv;
  logic  mode_block;
  logic  idx_ok;

  always_comb begin
    priv = priv_e'(priv_i);
    unique case (priv)
      PRIV_M:  mode_block = ctl_i.minh;
      PRIV_S:  mode_block = virt_i ? ctl_i.vsinh : ctl_i.sinh;
      PRIV_U:  mode_block = virt_i ? ctl_i.vuinh : ctl_i.uinh;
      default: mode_block = 1'b0;
    endcase
  end

  assign idx_ok = (int'(idx_i) >= IDX_LO) && (int'(idx_i) <= IDX_HI);
  assign take_o = incr_i && idx_ok && !inhibit_i && !mode_block;
endmodule

// File: rtl/hpc_count_reg.sv
module hpc_count_reg
  import hpc_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int HW = HALF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode32_i,
  input  logic         we_i,
  input  logic         whi_i,
  input  logic [W-1:0] wdata_i,
  input  logic         take_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam int NH = W / HW;

  logic          step;
  logic [NH:0]   carry;
  logic [W-1:0]  cnt_d;
  logic [W-1:0]  cnt_q;
  logic [NH-1:0] half_en;

  assign step     = take_i && !we_i;
  assign carry[0] = step;

  for (genvar g = 0; g < NH; g++) begin : g_half
    logic [HW-1:0] cur;
    logic          sel;
    assign cur          = cnt_q[g*HW +: HW];
    assign carry[g+1]   = carry[g] && (&cur);
    assign sel          = mode32_i ? (whi_i == g[0]) : 1'b1;

    always_comb begin
      cnt_d[g*HW +: HW] = cur;
      half_en[g]        = 1'b0;
      if (we_i) begin
        if (sel) begin
          half_en[g]        = 1'b1;
          cnt_d[g*HW +: HW] = mode32_i ? wdata_i[HW-1:0] : wdata_i[g*HW +: HW];
        end
      end else if (carry[g]) begin
        half_en[g]        = 1'b1;
        cnt_d[g*HW +: HW] = cur + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q[g*HW +: HW] <= '0;
      else if (half_en[g]) cnt_q[g*HW +: HW] <= cnt_d[g*HW +: HW];
    end
  end

  assign wrap_o = carry[NH];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/hpc_event_reg.sv
module hpc_event_reg
  import hpc_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int HW = HALF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode32_i,
  input  logic         we_i,
  input  logic         whi_i,
  input  logic [W-1:0] wdata_i,
  input  logic         wrap_i,
  output logic [W-1:0] evt_o,
  output ctl_t         ctl_o,
  output logic         irq_o
);
  localparam int NH = W / HW;

  logic [W-1:0] evt_q, evt_d, wr_val;
  logic         evt_en;
  logic         irq_q, irq_d;
  logic         raise;

  for (genvar g = 0; g < NH; g++) begin : g_half
    logic sel;
    assign sel = mode32_i ? (whi_i == g[0]) : 1'b1;
    assign wr_val[g*HW +: HW] = !sel ? evt_q[g*HW +: HW] :
                                (mode32_i ? wdata_i[HW-1:0] : wdata_i[g*HW +: HW]);
  end

  assign raise = wrap_i && !we_i && !evt_q[OF_POS];

  always_comb begin
    evt_d  = evt_q;
    evt_en = 1'b0;
    irq_d  = irq_q;
    if (we_i) begin
      evt_en = 1'b1;
      evt_d  = wr_val;
      if (!wr_val[OF_POS]) irq_d = 1'b0;
    end else if (raise) begin
      evt_en        = 1'b1;
      evt_d[OF_POS] = 1'b1;
      irq_d         = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      evt_q <= '0;
    else if (evt_en) evt_q <= evt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign evt_o = evt_q;
  assign ctl_o = ctl_t'(evt_q[OF_POS:CTL_LSB]);
  assign irq_o = irq_q;
endmodule

// File: rtl/hpc_filtered_counter.sv
module hpc_filtered_counter
  import hpc_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int IDX_LO = 3,
  parameter int IDX_HI = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode32_i,
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  input  logic             inhibit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             incr_i,
  input  logic             cnt_we_i,
  input  logic             evt_we_i,
  input  logic             whi_i,
  input  logic [63:0]      wdata_i,
  output logic [63:0]      cnt_o,
  output logic [63:0]      evt_o,
  output logic             irq_o
);
  ctl_t ctl;
  logic take;
  logic wrap;

  hpc_mode_filter #(.IDX_W(IDX_W), .IDX_LO(IDX_LO), .IDX_HI(IDX_HI)) u_filter (
    .priv_i(priv_i), .virt_i(virt_i), .inhibit_i(inhibit_i), .idx_i(idx_i),
    .ctl_i(ctl), .incr_i(incr_i), .take_o(take)
  );

  hpc_count_reg #(.W(CNT_W), .HW(HALF_W)) u_count (
    .clk(clk), .rst_n(rst_n), .mode32_i(mode32_i), .we_i(cnt_we_i),
    .whi_i(whi_i), .wdata_i(wdata_i), .take_i(take),
    .cnt_o(cnt_o), .wrap_o(wrap)
  );

  hpc_event_reg #(.W(CNT_W), .HW(HALF_W)) u_event (
    .clk(clk), .rst_n(rst_n), .mode32_i(mode32_i), .we_i(evt_we_i),
    .whi_i(whi_i), .wdata_i(wdata_i), .wrap_i(wrap),
    .evt_o(evt_o), .ctl_o(ctl), .irq_o(irq_o)
  );
endmodule

// File: rtl/hpc_filtered_counter_chk.sv
module hpc_filtered_counter_chk #(
  parameter int IDX_W  = 6,
  parameter int IDX_LO = 3,
  parameter int IDX_HI = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode32_i,
  input logic             inhibit_i,
  input logic [IDX_W-1:0] idx_i,
  input logic             cnt_we_i,
  input logic             evt_we_i,
  input logic [63:0]      wdata_i,
  input logic [63:0]      cnt_o,
  input logic [63:0]      evt_o,
  input logic             irq_o
);
  logic idx_out;
  assign idx_out = (int'(idx_i) < IDX_LO) || (int'(idx_i) > IDX_HI);

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 64'd1));

  assert_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((inhibit_i || idx_out) && !cnt_we_i) |=> $stable(cnt_o));

  assert_irq_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (cnt_o == 64'd0) && ($past(cnt_o) == '1));

  assert_of_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o[63] && !evt_we_i) |=> evt_o[63]);

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> evt_o[63]);

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we_i && !mode32_i) |=> cnt_o == $past(wdata_i));
endmodule

bind hpc_filtered_counter hpc_filtered_counter_chk #(
  .IDX_W(IDX_W), .IDX_LO(IDX_LO), .IDX_HI(IDX_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode32_i(mode32_i), .inhibit_i(inhibit_i),
  .idx_i(idx_i), .cnt_we_i(cnt_we_i), .evt_we_i(evt_we_i), .wdata_i(wdata_i),
  .cnt_o(cnt_o), .evt_o(evt_o), .irq_o(irq_o)
);

// File: tb/hpc_filtered_counter_bench.sv
module hpc_filtered_counter_bench;
  localparam time PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode32, virt, inh, incr, cnt_we, evt_we, whi;
  logic [1:0]  priv;
  logic [5:0]  idx;
  logic [63:0] wdata;
  logic [63:0] cnt_o, evt_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [63:0] cnt;
    logic [63:0] evt;
    logic        irq;
    string       tag;
  } exp_t;
  exp_t sb[$];

  localparam logic [63:0] OF  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MI  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] SI  = 64'h2000_0000_0000_0000;
  localparam logic [63:0] VUI = 64'h0400_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  always #(PERIOD/2) clk = ~clk;

  hpc_filtered_counter u_hpc_filtered_counter (
    .clk(clk), .rst_n(rst_n), .mode32_i(mode32), .priv_i(priv), .virt_i(virt),
    .inhibit_i(inh), .idx_i(idx), .incr_i(incr), .cnt_we_i(cnt_we),
    .evt_we_i(evt_we), .whi_i(whi), .wdata_i(wdata),
    .cnt_o(cnt_o), .evt_o(evt_o), .irq_o(irq_o)
  );

  // monitor: compares one queued item at each falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (cnt_o !== e.cnt || evt_o !== e.evt || irq_o !== e.irq) begin
        fails++;
        $display("FAIL %s: cnt=%h evt=%h irq=%b expected cnt=%h evt=%h irq=%b",
                 e.tag, cnt_o, evt_o, irq_o, e.cnt, e.evt, e.irq);
      end
    end
  end

  task automatic idle();
    incr = 0; cnt_we = 0; evt_we = 0; whi = 0; wdata = '0;
  endtask

  // driver: inputs are set before the rising edge; expectation queued after it
  task automatic tick(input logic [63:0] c, input logic [63:0] ev,
                      input logic iq, input string tag);
    exp_t e;
    @(posedge clk);
    e.cnt = c; e.evt = ev; e.irq = iq; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    #1;
    idle();
  endtask

  task automatic bump(input logic [1:0] p, input logic v, input logic [63:0] c,
                      input logic [63:0] ev, input logic iq, input string tag);
    priv = p; virt = v; incr = 1;
    tick(c, ev, iq, tag);
  endtask

  task automatic wr_evt(input logic hi, input logic [63:0] d, input logic [63:0] c,
                        input logic [63:0] ev, input logic iq, input string tag);
    evt_we = 1; whi = hi; wdata = d;
    tick(c, ev, iq, tag);
  endtask

  task automatic wr_cnt(input logic hi, input logic [63:0] d, input logic [63:0] c,
                        input logic [63:0] ev, input logic iq, input string tag);
    cnt_we = 1; whi = hi; wdata = d;
    tick(c, ev, iq, tag);
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode32 = 0; virt = 0; inh = 0; priv = 2'b11; idx = 6'd5;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    tick(64'd0, 64'd0, 1'b0, "R1 reset state");

    bump(2'b11, 0, 64'd1, 64'd0, 0, "R2 first increment");
    bump(2'b01, 0, 64'd2, 64'd0, 0, "R2 second increment");
    bump(2'b00, 1, 64'd3, 64'd0, 0, "R2 third increment");

    wr_evt(0, MI, 64'd3, MI, 0, "R10 full-width control write");
    bump(2'b11, 0, 64'd3, MI, 0, "R3 machine inhibited");
    bump(2'b11, 1, 64'd3, MI, 0, "R3 machine inhibit ignores virt");
    bump(2'b01, 0, 64'd4, MI, 0, "R3 supervisor still counts");

    wr_evt(0, SI, 64'd4, SI, 0, "R10 control write");
    bump(2'b01, 0, 64'd4, SI, 0, "R3 supervisor inhibited");
    bump(2'b01, 1, 64'd5, SI, 0, "R3 supervisor inhibit off under virt");
    bump(2'b00, 0, 64'd6, SI, 0, "R3 user unaffected");

    wr_evt(0, VUI, 64'd6, VUI, 0, "R10 control write");
    bump(2'b00, 1, 64'd6, VUI, 0, "R3 virtual user inhibited");
    bump(2'b00, 0, 64'd7, VUI, 0, "R3 virtual user inhibit off without virt");
    bump(2'b11, 1, 64'd8, VUI, 0, "R3 machine under virt counts");

    wr_evt(0, 64'd0, 64'd8, 64'd0, 0, "R10 control cleared");
    inh = 1;
    bump(2'b11, 0, 64'd8, 64'd0, 0, "R4 global inhibit");
    inh = 0; idx = 6'd2;
    bump(2'b11, 0, 64'd8, 64'd0, 0, "R4 index below range");
    idx = 6'd32;
    bump(2'b11, 0, 64'd8, 64'd0, 0, "R4 index above range");
    idx = 6'd31;
    bump(2'b11, 0, 64'd9, 64'd0, 0, "R4 index at upper bound counts");
    idx = 6'd3;
    bump(2'b11, 0, 64'd10, 64'd0, 0, "R4 index at lower bound counts");

    incr = 1; priv = 2'b11;
    wr_cnt(0, ONES, ONES, 64'd0, 0, "R11 write wins over increment");
    bump(2'b11, 0, 64'd0, OF, 1, "R5 R6 wrap sets flag and irq");
    bump(2'b11, 0, 64'd1, OF, 1, "R8 irq holds");
    wr_evt(0, OF, 64'd1, OF, 1, "R8 write keeping flag keeps irq");
    wr_evt(0, 64'd0, 64'd1, 64'd0, 0, "R8 flag cleared drops irq");
    wr_evt(0, OF, 64'd1, OF, 0, "R7 software flag set raises no irq");
    wr_cnt(0, ONES, ONES, OF, 0, "R10 counter write");
    bump(2'b11, 0, 64'd0, OF, 0, "R7 wrap with flag set no irq");

    wr_cnt(0, ONES, ONES, OF, 0, "R11 counter preset");
    incr = 1; priv = 2'b11;
    wr_evt(0, 64'd0, 64'd0, 64'd0, 0, "R11 control write wins over wrap flag");

    mode32 = 1;
    wr_evt(0, 64'hFFFF_FFFF_0000_0001, 64'd0, 64'h0000_0000_0000_0001, 0,
           "R10 32-bit low control write");
    wr_evt(1, 64'h0000_0000_8000_0000, 64'd0, 64'h8000_0000_0000_0001, 0,
           "R10 32-bit high control write");
    wr_evt(1, 64'd0, 64'd0, 64'h0000_0000_0000_0001, 0, "R10 32-bit high clear");
    wr_evt(0, 64'd0, 64'd0, 64'd0, 0, "R10 32-bit low clear");
    wr_cnt(0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 64'd0, 0,
           "R10 32-bit low counter write");
    bump(2'b11, 0, 64'h0000_0001_0000_0000, 64'd0, 0, "R9 carry into high half");
    wr_cnt(1, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 64'd0, 0,
           "R10 32-bit high counter write");
    bump(2'b11, 0, 64'hFFFF_FFFF_0000_0001, 64'd0, 0, "R9 low half alone");
    wr_cnt(0, 64'h0000_0000_FFFF_FFFF, ONES, 64'd0, 0, "R10 32-bit low to all ones");
    bump(2'b11, 0, 64'd0, OF, 1, "R9 both halves clear on overflow");
    wr_evt(1, 64'h0000_0000_8400_0000, 64'd0, OF | VUI, 1,
           "R3 32-bit inhibit placement");
    bump(2'b00, 1, 64'd0, OF | VUI, 1, "R3 32-bit virtual user inhibited");
    wr_evt(1, 64'd0, 64'd0, 64'd0, 0, "R8 32-bit flag clear drops irq");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule